// File: doc/BRIEF.md
# SPI NOR Flash Transaction Monitor

This block is a passive observer for serial NOR flash traffic. An upstream SPI deserializer hands it one byte pair per transfer (the byte seen on the controller-to-memory lane and the byte seen on the memory-to-controller lane), plus a pulse whenever chip select changes level. The monitor follows each command through its opcode, address, dummy and data phases, and reports what it sees as a stream of one-cycle events. Each event carries a kind code, a 24-bit value field and a warning bit.

The byte input is a valid/ready stream. A byte transfers on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` drops for exactly one cycle after a dual-lane byte pair is accepted, because such a pair unpacks into two bytes that are consumed one per cycle. `in_ready` is also low in any cycle where `cs_change` is high, so a byte offered alongside a chip-select change waits until the following cycle. The event output has no back-pressure: each event is valid for a single cycle, one register stage after the byte or chip-select pulse that caused it.

Top module: `spi_flash_monitor`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `evt_valid` is 0 and `in_ready` is 1.
- R2: The first byte taken while idle is treated as an opcode. Recognised opcodes are 0x06, 0x05, 0x9F, 0x03, 0x0B, 0xBB, 0x20, 0x02 and 0x90. Each produces a command event: kind 0, value = opcode. Any other byte produces an unknown-command event (kind 8, value = byte), and the monitor stays idle, so the next byte is again an opcode. After 0x06 the monitor also stays idle.
- R3: A `cs_change` pulse abandons the current command. The byte position returns to the opcode slot and the partial address is cleared. In the cycle after a pulse, the only event that can appear is a block-end event.
- R4: If a `cs_change` pulse arrives after at least one data byte (kind 2) of the current transaction, a block-end event follows (kind 3, value = number of data bytes). No block-end event appears when no data byte was seen.
- R5: Read (0x03): the next three MOSI bytes are the address, most significant byte first. After the third of them an address event appears (kind 1, value = 24-bit address). Every later MISO byte is a data event (kind 2).
- R6: Fast read (0x0B): same as R5, except that the byte after the address is a dummy byte that produces no event. Data starts at the sixth byte.
- R7: Page program (0x02): address as in R5. The data events take their value from MOSI instead of MISO.
- R8: Status read (0x05): every MISO byte after the opcode produces a status event (kind 4), for as long as the transaction lasts.
- R9: ID read (0x9F): the three MISO bytes after the opcode produce, in order, a manufacturer-ID event (kind 5), a memory-type event (kind 6) and a device-ID event (kind 7). The monitor then goes idle.
- R10: Sector erase (0x20): the address event carries a warning bit of 1 when the address is not a multiple of 4096, and 0 otherwise. The monitor then goes idle. No other event kind ever carries the warning bit.
- R11: Manufacturer/device ID (0x90): two dummy bytes are followed by a selector byte on MOSI. The next two MISO bytes are reported as kind 5 then kind 7 when the selector is 0x00, and as kind 7 then kind 5 otherwise. The monitor then goes idle.
- R12: Dual read (0xBB): each pair after the opcode holds even bits on MOSI and odd bits on MISO. The high nibbles of the pair form a first byte and the low nibbles form a second byte. These two bytes run through the fast-read sequence of R6 in that order. `in_ready` is 0 in the cycle after such a pair is accepted.
- R13: The byte position saturates instead of wrapping. A data phase of any length keeps producing data events and never re-enters the address phase.
- R14: `in_ready` is 0 in every cycle where `cs_change` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_change | input | 1 | One-cycle pulse on any chip-select level change |
| in_valid | input | 1 | Byte pair offered |
| in_ready | output | 1 | Byte pair may transfer this cycle |
| in_mosi | input | 8 | Byte from the controller-to-memory lane |
| in_miso | input | 8 | Byte from the memory-to-controller lane |
| evt_valid | output | 1 | Event strobe, one cycle per event |
| evt_kind | output | 4 | Event kind code |
| evt_data | output | 24 | Opcode, address, data byte, ID, status or count |
| evt_warn | output | 1 | Misaligned sector-erase address |

## Verification
Two situations are hard to reach from the ports. The first is the dual-lane path: each wire pair must carry the right interleaved bit pattern, the second unpacked byte has to land in the cycle after the stall, and the address, dummy and data bytes have to straddle pair boundaries. The bench uses a packing function of its own to spread the intended address, dummy and data bytes across both lanes, and checks the stall on `in_ready`. The second is index saturation: a 20-byte read runs the position counter past its maximum, and every byte must still come out as data, with a count of 20 at the end.

// File: rtl/spimon_pkg.sv
package spimon_pkg;

  typedef enum logic [3:0] {
    EV_CMD     = 4'd0,
    EV_ADDR    = 4'd1,
    EV_DATA    = 4'd2,
    EV_END     = 4'd3,
    EV_STATUS  = 4'd4,
    EV_MFR     = 4'd5,
    EV_MEMTYPE = 4'd6,
    EV_DEVID   = 4'd7,
    EV_UNKNOWN = 4'd8
  } evt_kind_e;

  typedef enum logic [3:0] {
    OP_IDLE,
    OP_STAT,
    OP_IDRD,
    OP_READ,
    OP_FREAD,
    OP_DREAD,
    OP_ERASE,
    OP_PROG,
    OP_MDID
  } op_e;

  localparam logic [7:0] CMD_WR_ENABLE  = 8'h06;
  localparam logic [7:0] CMD_STATUS_RD  = 8'h05;
  localparam logic [7:0] CMD_ID_RD      = 8'h9F;
  localparam logic [7:0] CMD_READ       = 8'h03;
  localparam logic [7:0] CMD_READ_FAST  = 8'h0B;
  localparam logic [7:0] CMD_READ_DUAL  = 8'hBB;
  localparam logic [7:0] CMD_SECT_ERASE = 8'h20;
  localparam logic [7:0] CMD_PAGE_PROG  = 8'h02;
  localparam logic [7:0] CMD_MFR_DEV_ID = 8'h90;

endpackage

// File: rtl/spimon_dual_merge.sv
// Rebuilds two bytes from a lane pair: lane0 holds even bits, lane1 odd bits.
// Upper halves of the lanes form the first byte, lower halves the second.
module spimon_dual_merge #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] lane0,
  input  logic [BYTE_W-1:0] lane1,
  output logic [BYTE_W-1:0] first_b,
  output logic [BYTE_W-1:0] second_b
);
  localparam int HALF = BYTE_W / 2;

  for (genvar i = 0; i < HALF; i++) begin : g_bit
    assign first_b[2*i]    = lane0[HALF+i];
    assign first_b[2*i+1]  = lane1[HALF+i];
    assign second_b[2*i]   = lane0[i];
    assign second_b[2*i+1] = lane1[i];
  end
endmodule

// File: rtl/spimon_block_count.sv
// Counts data bytes of the open block and reports the count on chip-select change.
module spimon_block_count #(
  parameter int CNT_W = 16,
  parameter int OUT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_evt,
  input  logic             data_strobe,
  output logic             end_valid,
  output logic [OUT_W-1:0] end_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             open_q;
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      count_q   <= '0;
      end_valid <= 1'b0;
      end_count <= '0;
    end else begin
      end_valid <= 1'b0;
      if (cs_evt) begin
        end_valid <= open_q;
        end_count <= OUT_W'(count_q);
        open_q    <= 1'b0;
        count_q   <= '0;
      end else if (data_strobe) begin
        open_q <= 1'b1;
        if (count_q != CNT_MAX) count_q <= count_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/spimon_seq.sv
// Per-command byte-position sequencer. Produces one registered event per fed byte at most.
module spimon_seq
  import spimon_pkg::*;
#(
  parameter int ADDR_W          = 24,
  parameter int IDX_W           = 4,
  parameter int SECT_ALIGN_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_evt,
  input  logic              feed_valid,
  input  logic [7:0]        feed_mosi,
  input  logic [7:0]        feed_miso,
  output logic              dual_phase,
  output logic              data_strobe,
  output logic              ev_valid,
  output evt_kind_e         ev_kind,
  output logic [ADDR_W-1:0] ev_data,
  output logic              ev_warn
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam logic [IDX_W-1:0] IDX_ONE    = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_FIRST  = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_MAX    = '1;
  localparam logic [IDX_W-1:0] ADDR_LAST  = IDX_W'(ADDR_BYTES + 1);
  localparam logic [IDX_W-1:0] DATA_PLAIN = IDX_W'(ADDR_BYTES + 2);
  localparam logic [IDX_W-1:0] DATA_FAST  = IDX_W'(ADDR_BYTES + 3);
  localparam logic [IDX_W-1:0] ID_MFR     = IDX_W'(2);
  localparam logic [IDX_W-1:0] ID_MEM     = IDX_W'(3);
  localparam logic [IDX_W-1:0] MD_SEL     = IDX_W'(4);
  localparam logic [IDX_W-1:0] MD_ID0     = IDX_W'(5);
  localparam logic [IDX_W-1:0] MD_ID1     = IDX_W'(6);

  op_e               op_q, op_n;
  logic [IDX_W-1:0]  idx_q, idx_n, idx_inc;
  logic [ADDR_W-1:0] addr_q, addr_n, addr_shift;
  logic              mfr_first_q, mfr_first_n;
  logic              e_v, e_w;
  evt_kind_e         e_k;
  logic [ADDR_W-1:0] e_d;
  logic [IDX_W-1:0]  data_start;

  assign dual_phase = (op_q == OP_DREAD);
  assign idx_inc    = (idx_q == IDX_MAX) ? idx_q : idx_q + IDX_ONE;
  assign addr_shift = {addr_q[ADDR_W-9:0], feed_mosi};
  assign data_start = (op_q == OP_READ || op_q == OP_PROG) ? DATA_PLAIN : DATA_FAST;

  always_comb begin
    op_n        = op_q;
    idx_n       = idx_q;
    addr_n      = addr_q;
    mfr_first_n = mfr_first_q;
    e_v         = 1'b0;
    e_k         = EV_CMD;
    e_d         = '0;
    e_w         = 1'b0;
    data_strobe = 1'b0;
    if (cs_evt) begin
      op_n   = OP_IDLE;
      idx_n  = IDX_ONE;
      addr_n = '0;
    end else if (feed_valid) begin
      case (op_q)
        OP_IDLE: begin
          e_v   = 1'b1;
          e_d   = ADDR_W'(feed_mosi);
          idx_n = IDX_FIRST;
          case (feed_mosi)
            CMD_WR_ENABLE:  idx_n = IDX_ONE;
            CMD_STATUS_RD:  op_n  = OP_STAT;
            CMD_ID_RD:      op_n  = OP_IDRD;
            CMD_READ:       op_n  = OP_READ;
            CMD_READ_FAST:  op_n  = OP_FREAD;
            CMD_READ_DUAL:  op_n  = OP_DREAD;
            CMD_SECT_ERASE: op_n  = OP_ERASE;
            CMD_PAGE_PROG:  op_n  = OP_PROG;
            CMD_MFR_DEV_ID: op_n  = OP_MDID;
            default: begin
              e_k   = EV_UNKNOWN;
              idx_n = IDX_ONE;
            end
          endcase
        end
        OP_READ, OP_FREAD, OP_DREAD, OP_PROG, OP_ERASE: begin
          idx_n = idx_inc;
          if (idx_q <= ADDR_LAST) begin
            addr_n = addr_shift;
            if (idx_q == ADDR_LAST) begin
              e_v    = 1'b1;
              e_k    = EV_ADDR;
              e_d    = addr_shift;
              addr_n = '0;
              if (op_q == OP_ERASE) begin
                e_w   = |addr_shift[SECT_ALIGN_BITS-1:0];
                op_n  = OP_IDLE;
                idx_n = IDX_ONE;
              end
            end
          end else if (idx_q >= data_start) begin
            e_v         = 1'b1;
            e_k         = EV_DATA;
            e_d         = ADDR_W'((op_q == OP_PROG) ? feed_mosi : feed_miso);
            data_strobe = 1'b1;
          end
        end
        OP_STAT: begin
          idx_n = idx_inc;
          e_v   = 1'b1;
          e_k   = EV_STATUS;
          e_d   = ADDR_W'(feed_miso);
        end
        OP_IDRD: begin
          idx_n = idx_inc;
          e_v   = 1'b1;
          e_d   = ADDR_W'(feed_miso);
          if (idx_q == ID_MFR) e_k = EV_MFR;
          else if (idx_q == ID_MEM) e_k = EV_MEMTYPE;
          else begin
            e_k   = EV_DEVID;
            op_n  = OP_IDLE;
            idx_n = IDX_ONE;
          end
        end
        OP_MDID: begin
          idx_n = idx_inc;
          e_d   = ADDR_W'(feed_miso);
          if (idx_q == MD_SEL) begin
            mfr_first_n = (feed_mosi == 8'h00);
          end else if (idx_q == MD_ID0) begin
            e_v = 1'b1;
            e_k = mfr_first_q ? EV_MFR : EV_DEVID;
          end else if (idx_q == MD_ID1) begin
            e_v   = 1'b1;
            e_k   = mfr_first_q ? EV_DEVID : EV_MFR;
            op_n  = OP_IDLE;
            idx_n = IDX_ONE;
          end
        end
        default: begin
          op_n  = OP_IDLE;
          idx_n = IDX_ONE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q        <= OP_IDLE;
      idx_q       <= IDX_ONE;
      addr_q      <= '0;
      mfr_first_q <= 1'b1;
      ev_valid    <= 1'b0;
      ev_kind     <= EV_CMD;
      ev_data     <= '0;
      ev_warn     <= 1'b0;
    end else begin
      op_q        <= op_n;
      idx_q       <= idx_n;
      addr_q      <= addr_n;
      mfr_first_q <= mfr_first_n;
      ev_valid    <= e_v;
      ev_kind     <= e_k;
      ev_data     <= e_d;
      ev_warn     <= e_w;
    end
  end
endmodule

// File: rtl/spi_flash_monitor.sv
module spi_flash_monitor
  import spimon_pkg::*;
#(
  parameter int ADDR_W          = 24,
  parameter int IDX_W           = 4,
  parameter int CNT_W           = 16,
  parameter int SECT_ALIGN_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_change,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_mosi,
  input  logic [7:0]        in_miso,
  output logic              evt_valid,
  output logic [3:0]        evt_kind,
  output logic [ADDR_W-1:0] evt_data,
  output logic              evt_warn
);
  logic              pend;
  logic [7:0]        held;
  logic [7:0]        dual_a, dual_b;
  logic              accept, dual_phase, data_strobe;
  logic              feed_valid;
  logic [7:0]        feed_mosi, feed_miso;
  logic              seq_valid, seq_warn, end_valid;
  evt_kind_e         seq_kind;
  logic [ADDR_W-1:0] seq_data, end_count;

  assign in_ready = !pend && !cs_change;
  assign accept   = in_valid && in_ready;

  spimon_dual_merge #(.BYTE_W(8)) u_merge (
    .lane0    (in_mosi),
    .lane1    (in_miso),
    .first_b  (dual_a),
    .second_b (dual_b)
  );

  always_comb begin
    feed_valid = (accept || pend) && !cs_change;
    if (pend) begin
      feed_mosi = held;
      feed_miso = held;
    end else if (dual_phase) begin
      feed_mosi = dual_a;
      feed_miso = dual_a;
    end else begin
      feed_mosi = in_mosi;
      feed_miso = in_miso;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      held <= '0;
    end else if (cs_change) begin
      pend <= 1'b0;
    end else if (pend) begin
      pend <= 1'b0;
    end else if (accept && dual_phase) begin
      pend <= 1'b1;
      held <= dual_b;
    end
  end

  spimon_seq #(
    .ADDR_W          (ADDR_W),
    .IDX_W           (IDX_W),
    .SECT_ALIGN_BITS (SECT_ALIGN_BITS)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_evt      (cs_change),
    .feed_valid  (feed_valid),
    .feed_mosi   (feed_mosi),
    .feed_miso   (feed_miso),
    .dual_phase  (dual_phase),
    .data_strobe (data_strobe),
    .ev_valid    (seq_valid),
    .ev_kind     (seq_kind),
    .ev_data     (seq_data),
    .ev_warn     (seq_warn)
  );

  spimon_block_count #(
    .CNT_W (CNT_W),
    .OUT_W (ADDR_W)
  ) u_blk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_evt      (cs_change),
    .data_strobe (data_strobe),
    .end_valid   (end_valid),
    .end_count   (end_count)
  );

  always_comb begin
    evt_valid = seq_valid || end_valid;
    if (end_valid) begin
      evt_kind = EV_END;
      evt_data = end_count;
      evt_warn = 1'b0;
    end else begin
      evt_kind = seq_kind;
      evt_data = seq_data;
      evt_warn = seq_warn;
    end
  end
endmodule

// File: rtl/spimon_checker.sv
module spimon_checker
  import spimon_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cs_change,
  input logic       in_valid,
  input logic       in_ready,
  input logic       evt_valid,
  input logic [3:0] evt_kind,
  input logic       evt_warn,
  input logic       pend,
  input logic       dual_phase
);
  localparam logic [3:0] K_END  = EV_END;
  localparam logic [3:0] K_ADDR = EV_ADDR;

  assert_ready_low_on_cs_R14: assert property (@(posedge clk) disable iff (!rst_n)
    cs_change |-> !in_ready);

  assert_dual_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && dual_phase) |=> !in_ready);

  assert_end_follows_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == K_END) |-> $past(cs_change));

  assert_cs_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_change) && evt_valid) |-> (evt_kind == K_END));

  assert_warn_on_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_warn) |-> (evt_kind == K_ADDR));

  assert_event_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> ($past(in_valid && in_ready) || $past(pend) || $past(cs_change)));
endmodule

bind spi_flash_monitor spimon_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_change  (cs_change),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .evt_valid  (evt_valid),
  .evt_kind   (evt_kind),
  .evt_warn   (evt_warn),
  .pend       (pend),
  .dual_phase (dual_phase)
);

// File: tb/sim_spi_flash_monitor.sv
`timescale 1ns/1ps
module sim_spi_flash_monitor;
  localparam logic [3:0] K_CMD = 4'd0, K_ADDR = 4'd1, K_DATA = 4'd2, K_END = 4'd3,
                         K_STAT = 4'd4, K_MFR = 4'd5, K_MEM = 4'd6, K_DEV = 4'd7,
                         K_UNK = 4'd8;

  typedef struct {
    logic [3:0]  kind;
    logic [23:0] data;
    logic        warn;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_change = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_mosi = '0;
  logic [7:0]  in_miso = '0;
  logic        in_ready, evt_valid, evt_warn;
  logic [3:0]  evt_kind;
  logic [23:0] evt_data;

  int total = 0;
  int bad = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  spi_flash_monitor u0 (
    .clk(clk), .rst_n(rst_n), .cs_change(cs_change),
    .in_valid(in_valid), .in_ready(in_ready), .in_mosi(in_mosi), .in_miso(in_miso),
    .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_data(evt_data), .evt_warn(evt_warn)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic expect_ev(input logic [3:0] k, input logic [23:0] d, input logic w, input string req);
    exp_t e;
    e.kind = k; e.data = d; e.warn = w; e.req = req;
    q.push_back(e);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && evt_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "unexpected event", {4'h0, evt_kind, evt_data}, 32'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(evt_kind == e.kind && evt_data == e.data && evt_warn == e.warn, e.req,
              {3'b0, evt_warn, evt_kind, evt_data}, {3'b0, e.warn, e.kind, e.data});
      end
    end
  end

  task automatic send(input logic [7:0] mo, input logic [7:0] mi);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_mosi = mo; in_miso = mi;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic cs_pulse();
    while (!in_ready) @(negedge clk);
    cs_change = 1'b1;
    #1;
    check(in_ready == 1'b0, "R14 ready during cs", {31'b0, in_ready}, 32'h0);
    @(negedge clk);
    cs_change = 1'b0;
  endtask

  function automatic logic [15:0] pack_dual(input logic [7:0] hi, input logic [7:0] lo);
    logic [7:0] mo, mi;
    for (int i = 0; i < 4; i++) begin
      mo[4+i] = hi[2*i];   mi[4+i] = hi[2*i+1];
      mo[i]   = lo[2*i];   mi[i]   = lo[2*i+1];
    end
    return {mo, mi};
  endfunction

  task automatic send_dual(input logic [7:0] hi, input logic [7:0] lo);
    logic [15:0] p;
    p = pack_dual(hi, lo);
    send(p[15:8], p[7:0]);
    check(in_ready == 1'b0, "R12 stall after pair", {31'b0, in_ready}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(evt_valid == 1'b0, "R1 reset valid", {31'b0, evt_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(evt_valid == 1'b0 && in_ready == 1'b1, "R1 after reset",
          {30'b0, evt_valid, in_ready}, 32'h1);

    // R5 plain read
    expect_ev(K_CMD, 24'h03, 0, "R2 read opcode");
    expect_ev(K_ADDR, 24'h123456, 0, "R5 address");
    expect_ev(K_DATA, 24'hA1, 0, "R5 data");
    expect_ev(K_DATA, 24'hA2, 0, "R5 data");
    expect_ev(K_DATA, 24'hA3, 0, "R5 data");
    expect_ev(K_END, 24'd3, 0, "R4 count");
    send(8'h03, 8'hFF); send(8'h12, 8'h00); send(8'h34, 8'h00); send(8'h56, 8'h00);
    send(8'h00, 8'hA1); send(8'h00, 8'hA2); send(8'h00, 8'hA3);
    cs_pulse();

    // R6 fast read with dummy
    expect_ev(K_CMD, 24'h0B, 0, "R2 fast opcode");
    expect_ev(K_ADDR, 24'h00AB12, 0, "R6 address");
    expect_ev(K_DATA, 24'h77, 0, "R6 data");
    expect_ev(K_DATA, 24'h88, 0, "R6 data");
    expect_ev(K_END, 24'd2, 0, "R4 count fast");
    send(8'h0B, 8'h00); send(8'h00, 8'h00); send(8'hAB, 8'h00); send(8'h12, 8'h00);
    send(8'h99, 8'h66);
    send(8'h00, 8'h77); send(8'h00, 8'h88);
    cs_pulse();

    // R7 page program from MOSI
    expect_ev(K_CMD, 24'h02, 0, "R2 prog opcode");
    expect_ev(K_ADDR, 24'h040100, 0, "R7 address");
    expect_ev(K_DATA, 24'h5C, 0, "R7 mosi data");
    expect_ev(K_DATA, 24'h3D, 0, "R7 mosi data");
    expect_ev(K_END, 24'd2, 0, "R4 count prog");
    send(8'h02, 8'h00); send(8'h04, 8'h00); send(8'h01, 8'h00); send(8'h00, 8'h00);
    send(8'h5C, 8'hEE); send(8'h3D, 8'hEE);
    cs_pulse();

    // R8 status repeats, no block end
    expect_ev(K_CMD, 24'h05, 0, "R2 status opcode");
    expect_ev(K_STAT, 24'h03, 0, "R8 status");
    expect_ev(K_STAT, 24'h02, 0, "R8 status");
    expect_ev(K_STAT, 24'h80, 0, "R8 status");
    send(8'h05, 8'h00); send(8'h00, 8'h03); send(8'h00, 8'h02); send(8'h00, 8'h80);
    cs_pulse();

    // R9 id read then idle (next byte is opcode)
    expect_ev(K_CMD, 24'h9F, 0, "R2 id opcode");
    expect_ev(K_MFR, 24'hC2, 0, "R9 mfr");
    expect_ev(K_MEM, 24'h20, 0, "R9 memtype");
    expect_ev(K_DEV, 24'h16, 0, "R9 dev");
    expect_ev(K_CMD, 24'h06, 0, "R9 idle after id");
    expect_ev(K_CMD, 24'h06, 0, "R2 write enable stays idle");
    send(8'h9F, 8'h00); send(8'h00, 8'hC2); send(8'h00, 8'h20); send(8'h00, 8'h16);
    send(8'h06, 8'h00); send(8'h06, 8'h00);
    cs_pulse();

    // R10 erase alignment
    expect_ev(K_CMD, 24'h20, 0, "R2 erase opcode");
    expect_ev(K_ADDR, 24'h001000, 0, "R10 aligned");
    expect_ev(K_CMD, 24'h20, 0, "R10 idle after erase");
    expect_ev(K_ADDR, 24'h012345, 1, "R10 misaligned warn");
    send(8'h20, 8'h00); send(8'h00, 8'h00); send(8'h10, 8'h00); send(8'h00, 8'h00);
    send(8'h20, 8'h00); send(8'h01, 8'h00); send(8'h23, 8'h00); send(8'h45, 8'h00);
    cs_pulse();

    // R2 unknown opcode then idle
    expect_ev(K_UNK, 24'h77, 0, "R2 unknown");
    expect_ev(K_CMD, 24'h05, 0, "R2 idle after unknown");
    send(8'h77, 8'h00); send(8'h05, 8'h00);
    cs_pulse();

    // R11 selector orders
    expect_ev(K_CMD, 24'h90, 0, "R2 mdid opcode");
    expect_ev(K_MFR, 24'hEF, 0, "R11 mfr first");
    expect_ev(K_DEV, 24'h17, 0, "R11 dev second");
    send(8'h90, 8'h00); send(8'h00, 8'h00); send(8'h00, 8'h00); send(8'h00, 8'h00);
    send(8'h00, 8'hEF); send(8'h00, 8'h17);
    cs_pulse();
    expect_ev(K_CMD, 24'h90, 0, "R2 mdid opcode");
    expect_ev(K_DEV, 24'h17, 0, "R11 dev first");
    expect_ev(K_MFR, 24'hEF, 0, "R11 mfr second");
    send(8'h90, 8'h00); send(8'h00, 8'h00); send(8'h00, 8'h00); send(8'h01, 8'h00);
    send(8'h00, 8'h17); send(8'h00, 8'hEF);
    cs_pulse();

    // R3 abandoned command, address cleared
    expect_ev(K_CMD, 24'h03, 0, "R3 partial");
    send(8'h03, 8'h00); send(8'h12, 8'h00);
    cs_pulse();
    expect_ev(K_CMD, 24'h03, 0, "R3 restart opcode");
    expect_ev(K_ADDR, 24'h000001, 0, "R3 address cleared");
    send(8'h03, 8'h00); send(8'h00, 8'h00); send(8'h00, 8'h00); send(8'h01, 8'h00);
    cs_pulse();

    // R12 dual read
    expect_ev(K_CMD, 24'hBB, 0, "R2 dual opcode");
    expect_ev(K_ADDR, 24'hABCDEF, 0, "R12 dual address");
    expect_ev(K_DATA, 24'h5A, 0, "R12 dual data");
    expect_ev(K_DATA, 24'hC3, 0, "R12 dual data");
    expect_ev(K_END, 24'd2, 0, "R12 dual count");
    send(8'hBB, 8'h00);
    send_dual(8'hAB, 8'hCD);
    send_dual(8'hEF, 8'h00);
    send_dual(8'h5A, 8'hC3);
    cs_pulse();

    // R13 long read saturates index
    expect_ev(K_CMD, 24'h03, 0, "R13 opcode");
    expect_ev(K_ADDR, 24'h000010, 0, "R13 address");
    for (int i = 0; i < 20; i++) expect_ev(K_DATA, 24'(8'h40 + i), 0, "R13 long data");
    expect_ev(K_END, 24'd20, 0, "R13 long count");
    send(8'h03, 8'h00); send(8'h00, 8'h00); send(8'h00, 8'h00); send(8'h10, 8'h00);
    for (int i = 0; i < 20; i++) send(8'h03, 8'(8'h40 + i));
    cs_pulse();

    repeat (4) @(negedge clk);
    check(q.size() == 0, "missing events", q.size(), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule